// File: doc/BRIEF.md
# Delayed Write Tracker

This block sits on the initiator side of a bus bridge and handles the writes that cannot be posted, such as I/O writes and Type 1 configuration writes. The first time an initiator presents such a write, the tracker claims it and answers with a target retry. It also stores the command, the address, the single data word and the byte enables in a four-slot queue. The initiator is expected to come back later with the same write. Until the write has been delivered, every repeat is retried again and no second slot is used.

The entry at the queue head is replayed on the target bus once the posted-write ordering logic grants permission. The replay is reissued on each target retry, until a programmable attempt limit is used up. A completed head entry waits for the initiator's repeat. The repeat must match in command, address and byte enables, and in the data bytes that are enabled. When it does, the repeat receives the final status and the slot is freed. A completion that nobody claims is dropped when a programmable discard timer runs out. An exhausted retry budget or an expired timer raises an error flag, and a system-error output follows it when enabled.

Top module: `dwt_tracker`

## Requirements
- R1: A request whose command and address match no queued entry, while fewer than 4 entries are held, gets a retry response (rsp_devsel=1, rsp_stop=1, rsp_trdy=0, rsp_retry=1) in the cycle after it is presented, and it is stored as a new entry.
- R2: When all 4 slots are occupied, a request for a new address still gets a retry, but no entry is created, so it is never launched on the target bus.
- R3: A repeat with the same command and address as a queued entry that has not yet completed gets a retry and creates no second entry. Only one target launch results.
- R4: tgt_req is high only while the head entry is awaiting delivery and ord_ok is high. Entries launch in arrival order. tgt_res is sampled with tgt_ack and is encoded as 0 = delivered, 1 = target retry, 2 = target abort. After a delivered result, tgt_req drops in the next cycle.
- R5: Each target retry of the head is counted. The retry that brings the count to cfg_retry_limit drops the entry and pulses err_flag for one cycle. serr pulses with it only when cfg_serr_en is 1.
- R6: A repeat claims the completed head entry only if command, address and byte enables are equal, and the data is equal in every byte whose active-low enable req_be_n[i] is 0 (byte i = data bits 8i+7..8i). A claim answers rsp_devsel=1, rsp_trdy=1 and frees the slot. A mismatch, or a match on an entry that is not at the head, gets a retry.
- R7: On a successful claim, rsp_stop equals req_multi (the initiator wants more than one word).
- R8: A completion unclaimed for more than cfg_discard+1 cycles after its delivery result is dropped, err_flag pulses, and serr pulses if enabled. A later repeat is then handled as a new write.
- R9: A target abort completes the entry with an error. Its claiming repeat gets rsp_stop=1 with rsp_devsel=0 and rsp_trdy=0, and the slot is freed.
- R10: After reset, no response, target request, err_flag or serr is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle strobe: an initiator write attempt with its captured fields |
| req_cmd | input | 4 | Bus command of the attempt |
| req_addr | input | 32 | Address of the attempt |
| req_data | input | 32 | First data word |
| req_be_n | input | 4 | Active-low byte enables |
| req_multi | input | 1 | Initiator wants more than one data word |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| rsp_devsel | output | 1 | Claim the access |
| rsp_trdy | output | 1 | Data accepted (write completed) |
| rsp_stop | output | 1 | Stop or disconnect |
| rsp_retry | output | 1 | Response is a target retry |
| ord_ok | input | 1 | Ordering against posted writes permits a launch |
| tgt_req | output | 1 | Head write awaits launch on the target bus |
| tgt_cmd | output | 4 | Command of the head write |
| tgt_addr | output | 32 | Address of the head write |
| tgt_data | output | 32 | Data of the head write |
| tgt_be_n | output | 4 | Byte enables of the head write |
| tgt_ack | input | 1 | One-cycle strobe: target attempt finished |
| tgt_res | input | 2 | Attempt result: 0 delivered, 1 retry, 2 abort |
| cfg_retry_limit | input | 32 | Number of target retries that exhausts an entry |
| cfg_discard | input | 16 | Discard timer load value |
| cfg_serr_en | input | 1 | Enables the serr output |
| err_flag | output | 1 | One-cycle pulse on retry exhaustion or discard |
| serr | output | 1 | err_flag gated by cfg_serr_en |

## Verification
A corrupted slot, pointer or occupancy count is seen on the target side first. tgt_req stays high after a delivery or never comes up, or the tgt_addr sequence departs from arrival order, as soon as the head reaches that slot. A wrong match or state bit shows one cycle after the repeat: a retry where a claim is due, or the reverse, or the wrong status bits. A miscounted attempt counter or discard timer moves err_flag from the cycle the limit predicts, or makes a later repeat still find a completion that should have been dropped.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
    parameter int DW_CMD  = 4;
    parameter int DW_ADDR = 32;
    parameter int DW_DATA = 32;
    parameter int DW_BE   = DW_DATA / 8;

    typedef enum logic [1:0] {
        TR_OK    = 2'd0,
        TR_RETRY = 2'd1,
        TR_ABORT = 2'd2
    } tgt_res_e;

    typedef enum logic [1:0] {
        ST_PEND = 2'd0,
        ST_DONE = 2'd1,
        ST_ABRT = 2'd2
    } ent_st_e;

    typedef struct packed {
        logic [DW_CMD-1:0]  cmd;
        logic [DW_ADDR-1:0] addr;
        logic [DW_DATA-1:0] data;
        logic [DW_BE-1:0]   be_n;
        ent_st_e            st;
    } dw_entry_t;

    // true when every byte enabled (active low) agrees
    function automatic logic masked_eq(input logic [DW_DATA-1:0] a,
                                       input logic [DW_DATA-1:0] b,
                                       input logic [DW_BE-1:0]   be_n);
        for (int i = 0; i < DW_BE; i++) begin
            if (!be_n[i] && (a[8*i +: 8] != b[8*i +: 8])) return 1'b0;
        end
        return 1'b1;
    endfunction
endpackage

// File: rtl/dwt_match.sv
module dwt_match
    import dwt_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  dw_entry_t            ents [DEPTH],
    input  logic [DEPTH-1:0]     live,
    input  logic [DW_CMD-1:0]    cmd,
    input  logic [DW_ADDR-1:0]   addr,
    input  logic [DW_DATA-1:0]   data,
    input  logic [DW_BE-1:0]     be_n,
    output logic                 hit,
    output logic [$clog2(DEPTH)-1:0] hit_idx,
    output logic                 hit_full
);
    localparam int IW = $clog2(DEPTH);

    logic [DEPTH-1:0] key_hit;
    logic [DEPTH-1:0] full_ok;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign key_hit[g] = live[g] && (ents[g].cmd == cmd) && (ents[g].addr == addr);
        assign full_ok[g] = (ents[g].be_n == be_n) && masked_eq(ents[g].data, data, be_n);
    end

    always_comb begin
        hit      = |key_hit;
        hit_idx  = '0;
        hit_full = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (key_hit[i]) begin
                hit_idx  = IW'(i);
                hit_full = full_ok[i];
            end
        end
    end
endmodule

// File: rtl/dwt_timers.sv
module dwt_timers #(
    parameter int CNT_W = 32,
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             retry_ev,
    input  logic             att_clr,
    input  logic [CNT_W-1:0] limit,
    input  logic             tmr_load,
    input  logic [TMR_W-1:0] tmr_init,
    input  logic             tmr_run,
    output logic             exhausted,
    output logic             tmr_zero
);
    logic [CNT_W-1:0] att_q;
    logic [TMR_W-1:0] tmr_q;
    logic [CNT_W:0]   att_next;

    assign att_next  = {1'b0, att_q} + 1'b1;
    assign exhausted = retry_ev && (att_next >= {1'b0, limit});
    assign tmr_zero  = (tmr_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            att_q <= '0;
            tmr_q <= '0;
        end else begin
            if (att_clr || exhausted) att_q <= '0;
            else if (retry_ev)        att_q <= att_next[CNT_W-1:0];

            if (tmr_load)                 tmr_q <= tmr_init;
            else if (tmr_run && !tmr_zero) tmr_q <= tmr_q - 1'b1;
        end
    end
endmodule

// File: rtl/dwt_tracker.sv
module dwt_tracker
    import dwt_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 32,
    parameter int TMR_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [DW_CMD-1:0]  req_cmd,
    input  logic [DW_ADDR-1:0] req_addr,
    input  logic [DW_DATA-1:0] req_data,
    input  logic [DW_BE-1:0]   req_be_n,
    input  logic               req_multi,
    output logic               rsp_valid,
    output logic               rsp_devsel,
    output logic               rsp_trdy,
    output logic               rsp_stop,
    output logic               rsp_retry,
    input  logic               ord_ok,
    output logic               tgt_req,
    output logic [DW_CMD-1:0]  tgt_cmd,
    output logic [DW_ADDR-1:0] tgt_addr,
    output logic [DW_DATA-1:0] tgt_data,
    output logic [DW_BE-1:0]   tgt_be_n,
    input  logic               tgt_ack,
    input  logic [1:0]         tgt_res,
    input  logic [CNT_W-1:0]   cfg_retry_limit,
    input  logic [TMR_W-1:0]   cfg_discard,
    input  logic               cfg_serr_en,
    output logic               err_flag,
    output logic               serr
);
    localparam int PW = $clog2(DEPTH);
    localparam int OW = PW + 1;

    dw_entry_t        ents [DEPTH];
    logic [PW-1:0]    head, tail;
    logic [OW-1:0]    occ;
    logic [DEPTH-1:0] live;
    dw_entry_t        hd;
    tgt_res_e         tres;

    logic          hit, hit_full;
    logic [PW-1:0] hit_idx;
    logic          head_pend, head_done;
    logic          pend_ack, cmpl, retry_ev;
    logic          claim, alloc, exhausted, tmr_zero, discard, pop;

    // slot is live when its distance from head is below the occupancy
    for (genvar g = 0; g < DEPTH; g++) begin : g_live
        logic [PW-1:0] offs;
        assign offs    = PW'(g) - head;
        assign live[g] = ({1'b0, offs} < occ);
    end

    assign hd        = ents[head];
    assign tres      = tgt_res_e'(tgt_res);
    assign head_pend = (occ != '0) && (hd.st == ST_PEND);
    assign head_done = (occ != '0) && (hd.st != ST_PEND);

    assign tgt_req  = head_pend && ord_ok;
    assign tgt_cmd  = hd.cmd;
    assign tgt_addr = hd.addr;
    assign tgt_data = hd.data;
    assign tgt_be_n = hd.be_n;

    dwt_match #(.DEPTH(DEPTH)) u_match (
        .ents     (ents),
        .live     (live),
        .cmd      (req_cmd),
        .addr     (req_addr),
        .data     (req_data),
        .be_n     (req_be_n),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .hit_full (hit_full)
    );

    assign pend_ack = tgt_ack && head_pend;
    assign cmpl     = pend_ack && ((tres == TR_OK) || (tres == TR_ABORT));
    assign retry_ev = pend_ack && (tres == TR_RETRY);

    dwt_timers #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_timers (
        .clk       (clk),
        .rst       (rst),
        .retry_ev  (retry_ev),
        .att_clr   (pop || cmpl),
        .limit     (cfg_retry_limit),
        .tmr_load  (cmpl),
        .tmr_init  (cfg_discard),
        .tmr_run   (head_done),
        .exhausted (exhausted),
        .tmr_zero  (tmr_zero)
    );

    assign claim   = req_valid && hit && (hit_idx == head) && head_done && hit_full;
    assign alloc   = req_valid && !hit && (occ < OW'(DEPTH));
    assign discard = head_done && tmr_zero && !claim;
    assign pop     = claim || exhausted || discard;

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
            occ  <= '0;
            for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
            rsp_valid  <= 1'b0;
            rsp_devsel <= 1'b0;
            rsp_trdy   <= 1'b0;
            rsp_stop   <= 1'b0;
            rsp_retry  <= 1'b0;
            err_flag   <= 1'b0;
            serr       <= 1'b0;
        end else begin
            if (alloc) begin
                ents[tail] <= '{cmd: req_cmd, addr: req_addr, data: req_data,
                                be_n: req_be_n, st: ST_PEND};
                tail <= tail + 1'b1;
            end
            if (cmpl) ents[head].st <= (tres == TR_ABORT) ? ST_ABRT : ST_DONE;
            if (pop)  head <= head + 1'b1;
            occ <= occ + OW'(alloc) - OW'(pop);

            rsp_valid <= req_valid;
            if (claim && hd.st == ST_ABRT) begin
                rsp_devsel <= 1'b0;
                rsp_trdy   <= 1'b0;
                rsp_stop   <= 1'b1;
                rsp_retry  <= 1'b0;
            end else if (claim) begin
                rsp_devsel <= 1'b1;
                rsp_trdy   <= 1'b1;
                rsp_stop   <= req_multi;
                rsp_retry  <= 1'b0;
            end else begin
                rsp_devsel <= req_valid;
                rsp_trdy   <= 1'b0;
                rsp_stop   <= req_valid;
                rsp_retry  <= req_valid;
            end

            err_flag <= exhausted || discard;
            serr     <= (exhausted || discard) && cfg_serr_en;
        end
    end
endmodule

// File: rtl/dwt_checker.sv
module dwt_checker #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       req_valid,
    input logic                       req_multi,
    input logic                       rsp_valid,
    input logic                       rsp_devsel,
    input logic                       rsp_trdy,
    input logic                       rsp_stop,
    input logic                       rsp_retry,
    input logic                       tgt_req,
    input logic                       tgt_ack,
    input logic [1:0]                 tgt_res,
    input logic                       err_flag,
    input logic                       serr,
    input logic [$clog2(DEPTH):0]     occ
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid)); // R1
    AST_RETRY_SHAPE: assert property (@(posedge clk) disable iff (rst)
        rsp_retry |-> (rsp_devsel && rsp_stop && !rsp_trdy)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ <= ($clog2(DEPTH)+1)'(DEPTH)); // R2
    AST_DELIVERED_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
        (tgt_req && tgt_ack && tgt_res == 2'd0) |=> !tgt_req); // R4
    AST_SERR_GATED: assert property (@(posedge clk) disable iff (rst)
        serr |-> err_flag); // R5
    AST_TRDY_CLAIMED: assert property (@(posedge clk) disable iff (rst)
        rsp_trdy |-> (rsp_devsel && !rsp_retry && rsp_valid)); // R6
    AST_MULTI_STOP: assert property (@(posedge clk) disable iff (rst)
        rsp_trdy |-> (rsp_stop == $past(req_multi))); // R7
    AST_ABORT_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_devsel) |-> (rsp_stop && !rsp_trdy)); // R9
endmodule

bind dwt_tracker dwt_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_multi  (req_multi),
    .rsp_valid  (rsp_valid),
    .rsp_devsel (rsp_devsel),
    .rsp_trdy   (rsp_trdy),
    .rsp_stop   (rsp_stop),
    .rsp_retry  (rsp_retry),
    .tgt_req    (tgt_req),
    .tgt_ack    (tgt_ack),
    .tgt_res    (tgt_res),
    .err_flag   (err_flag),
    .serr       (serr),
    .occ        (occ)
);

// File: tb/test_dwt_tracker.sv
`timescale 1ns/1ps
module test_dwt_tracker;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_multi;
    logic [3:0]  req_cmd, req_be_n;
    logic [31:0] req_addr, req_data;
    logic        rsp_valid, rsp_devsel, rsp_trdy, rsp_stop, rsp_retry;
    logic        ord_ok, tgt_req, tgt_ack;
    logic [3:0]  tgt_cmd, tgt_be_n;
    logic [31:0] tgt_addr, tgt_data;
    logic [1:0]  tgt_res;
    logic [31:0] cfg_retry_limit;
    logic [15:0] cfg_discard;
    logic        cfg_serr_en, err_flag, serr;

    int checks = 0;
    int errors = 0;
    int err_seen = 0;
    int serr_seen = 0;
    logic [2:0] exp_q [$];   // {devsel, trdy, stop}

    localparam logic [2:0] E_RETRY = 3'b101;
    localparam logic [2:0] E_DONE1 = 3'b110;
    localparam logic [2:0] E_DONEM = 3'b111;
    localparam logic [2:0] E_ABORT = 3'b001;

    always #2.5 clk = ~clk;

    dwt_tracker i_dwt_tracker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_data(req_data), .req_be_n(req_be_n),
        .req_multi(req_multi), .rsp_valid(rsp_valid), .rsp_devsel(rsp_devsel),
        .rsp_trdy(rsp_trdy), .rsp_stop(rsp_stop), .rsp_retry(rsp_retry),
        .ord_ok(ord_ok), .tgt_req(tgt_req), .tgt_cmd(tgt_cmd),
        .tgt_addr(tgt_addr), .tgt_data(tgt_data), .tgt_be_n(tgt_be_n),
        .tgt_ack(tgt_ack), .tgt_res(tgt_res), .cfg_retry_limit(cfg_retry_limit),
        .cfg_discard(cfg_discard), .cfg_serr_en(cfg_serr_en),
        .err_flag(err_flag), .serr(serr)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard on each response, counts error pulses
    always @(negedge clk) begin
        if (!rst) begin
            if (err_flag) err_seen++;
            if (serr)     serr_seen++;
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected response", 1, 0);
                end else begin
                    logic [2:0] e;
                    e = exp_q.pop_front();
                    check({rsp_devsel, rsp_trdy, rsp_stop} == e && rsp_retry == (e == E_RETRY),
                          "R1/R3/R6/R7/R9 response", {rsp_retry, rsp_devsel, rsp_trdy, rsp_stop},
                          {(e == E_RETRY), e});
                end
            end
        end
    end

    task automatic send(input logic [3:0] cmd, input logic [31:0] addr,
                        input logic [31:0] data, input logic [3:0] be_n,
                        input logic multi, input logic [2:0] exp);
        exp_q.push_back(exp);
        req_cmd = cmd; req_addr = addr; req_data = data; req_be_n = be_n;
        req_multi = multi; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_multi = 1'b0;
        @(negedge clk);
    endtask

    task automatic serve(input logic [31:0] addr, input logic [1:0] res, input string tag);
        while (!tgt_req) @(negedge clk);
        check(tgt_addr == addr, tag, tgt_addr, addr);
        tgt_ack = 1'b1; tgt_res = res;
        @(negedge clk);
        tgt_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 0; req_multi = 0; req_cmd = 0; req_addr = 0;
        req_data = 0; req_be_n = 0; ord_ok = 0; tgt_ack = 0; tgt_res = 0;
        cfg_retry_limit = 3; cfg_discard = 40; cfg_serr_en = 1;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(!rsp_valid && !tgt_req && !err_flag && !serr, "R10 reset outputs",
              {rsp_valid, tgt_req, err_flag, serr}, 0);

        // R1 new write retried and stored; R4 held until ord_ok
        send(4'h3, 32'h100, 32'hCAFE_0001, 4'h0, 0, E_RETRY);
        idle(4);
        check(!tgt_req, "R4 no launch without ord_ok", tgt_req, 0);
        ord_ok = 1'b1;
        @(negedge clk);
        check(tgt_req && tgt_data == 32'hCAFE_0001, "R1 stored data", tgt_data, 32'hCAFE_0001);
        serve(32'h100, 2'd0, "R4 launch A");
        check(!tgt_req, "R4 req drops after delivery", tgt_req, 0);
        send(4'h3, 32'h100, 32'hCAFE_0001, 4'h0, 0, E_DONE1); // R6 R7 single word

        // R3 repeat while pending
        send(4'hB, 32'h200, 32'h1234_5678, 4'h0, 0, E_RETRY);
        send(4'hB, 32'h200, 32'h1234_5678, 4'h0, 0, E_RETRY);
        serve(32'h200, 2'd0, "R3 launch B");
        check(!tgt_req, "R3 single launch", tgt_req, 0);
        send(4'hB, 32'h200, 32'h1234_5678, 4'h0, 1, E_DONEM); // R7 multi

        // R6 masked compare: bytes 0,1 enabled
        send(4'h3, 32'h300, 32'h1111_2222, 4'b1100, 0, E_RETRY);
        serve(32'h300, 2'd0, "R6 launch C");
        send(4'h3, 32'h300, 32'h1111_2223, 4'b1100, 0, E_RETRY); // enabled byte differs
        send(4'h3, 32'h300, 32'h1111_2222, 4'b1000, 0, E_RETRY); // enables differ
        send(4'h3, 32'h300, 32'hAAAA_2222, 4'b1100, 0, E_DONE1); // disabled bytes differ

        // R2 full queue and R4 order
        ord_ok = 1'b0;
        for (int k = 0; k < 5; k++)
            send(4'h3, 32'h400 + 32'(k) * 4, 32'(k), 4'h0, 0, E_RETRY);
        ord_ok = 1'b1;
        for (int k = 0; k < 4; k++) begin
            serve(32'h400 + 32'(k) * 4, 2'd0, "R4 arrival order");
            if (k == 0) send(4'h3, 32'h404, 32'd1, 4'h0, 0, E_RETRY); // R6 not head
            send(4'h3, 32'h400 + 32'(k) * 4, 32'(k), 4'h0, 0, E_DONE1);
        end
        idle(3);
        check(!tgt_req, "R2 fifth write not stored", tgt_req, 0);

        // R5 retry budget
        send(4'h3, 32'h500, 32'h5, 4'h0, 0, E_RETRY);
        serve(32'h500, 2'd1, "R5 retry 1");
        serve(32'h500, 2'd1, "R5 retry 2");
        check(err_seen == 0, "R5 no error below limit", err_seen, 0);
        serve(32'h500, 2'd0, "R5 delivered");
        send(4'h3, 32'h500, 32'h5, 4'h0, 0, E_DONE1);
        send(4'h3, 32'h600, 32'h6, 4'h0, 0, E_RETRY);
        for (int k = 0; k < 3; k++) serve(32'h600, 2'd1, "R5 retry F");
        check(err_seen == 1 && serr_seen == 1, "R5 exhaustion error", {err_seen[15:0], serr_seen[15:0]}, 32'h0001_0001);
        check(!tgt_req, "R5 entry dropped", tgt_req, 0);
        cfg_serr_en = 1'b0;
        send(4'h3, 32'h700, 32'h7, 4'h0, 0, E_RETRY);
        for (int k = 0; k < 3; k++) serve(32'h700, 2'd1, "R5 retry G");
        check(err_seen == 2 && serr_seen == 1, "R5 serr gated", {err_seen[15:0], serr_seen[15:0]}, 32'h0002_0001);

        // R9 target abort
        send(4'h3, 32'h800, 32'h8, 4'h0, 0, E_RETRY);
        serve(32'h800, 2'd2, "R9 launch H");
        send(4'h3, 32'h800, 32'h8, 4'h0, 0, E_ABORT);

        // R8 discard timer
        cfg_serr_en = 1'b1;
        cfg_discard = 5;
        send(4'h3, 32'h900, 32'h9, 4'h0, 0, E_RETRY);
        serve(32'h900, 2'd0, "R8 launch I");
        idle(20);
        check(err_seen == 3 && serr_seen == 2, "R8 discard error", {err_seen[15:0], serr_seen[15:0]}, 32'h0003_0002);
        cfg_discard = 40;
        send(4'h3, 32'h900, 32'h9, 4'h0, 0, E_RETRY); // treated as new
        serve(32'h900, 2'd0, "R8 relaunch I");
        send(4'h3, 32'h900, 32'h9, 4'h0, 0, E_DONE1);

        idle(3);
        check(exp_q.size() == 0, "R1 all responses seen", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule